// File: doc/BRIEF.md
# Strap-Configured Registered Fan-Out Buffer

This block is a register bank for the address and command path of a memory module. It samples an input bus on every rising clock edge and drives the sampled value onto a 28-bit output bus. The width and the shape of the path are set by two strap inputs that are tied off for the whole time the block runs.

With the fan-out strap low, the bank works as a plain 25-bit register. Each input bit drives one output bit, and the three spare outputs stay low. With the fan-out strap high, the bank works as a 14-bit register, and each registered bit drives two outputs: one in the lower half of the bus and one in the upper half. In that mode the bank-select strap picks the 14 input bits that are used. Low selects the low-order slice and high selects the high-order slice.

An active-low reset clears the bank at once and holds every output low. Capture starts on the first rising edge after reset is released.

Top module: `regbuf_fanout`

## Requirements
- R1: With `fanout_mode`=0, `dout[24:0]` equals the `din` sampled at the previous rising edge of `clk`.
- R2: With `fanout_mode`=0, `dout[27:25]` is 0.
- R3: With `fanout_mode`=1 and `upper_sel`=0, both `dout[13:0]` and `dout[27:14]` equal `din[13:0]` as sampled at the previous rising edge.
- R4: With `fanout_mode`=1 and `upper_sel`=1, both `dout[13:0]` and `dout[27:14]` equal `din[24:11]` as sampled at the previous rising edge.
- R5: With `fanout_mode`=0, `upper_sel` has no effect on `dout`.
- R6: While `rst_n` is 0, `dout` is all zeros. Asserting reset clears the outputs without waiting for a clock edge.
- R7: After `rst_n` rises between clock edges, the first rising edge that follows captures `din` under the rules of R1 to R4.
- R8: `fanout_mode` and `upper_sel` hold steady while `rst_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| fanout_mode | input | 1 | Strap: 0 = 25-bit one-to-one, 1 = 14-bit one-to-two |
| upper_sel | input | 1 | Strap: 14-bit input slice, 0 = bits 13:0, 1 = bits 24:11 |
| din | input | 25 | Data to be registered |
| dout | output | 28 | Registered outputs |

## Verification
The embedded properties treat the two straps as constant whenever reset is released. Each mapping property compares the outputs with the input from one edge earlier under the straps in force now, so a strap that changed between two edges would make a correct design look wrong. The stimulus therefore changes the straps only while reset is held, and it keeps reset low for several edges before releasing it. Inputs are driven on falling edges, and reset is released on a falling edge, so every capture sees stable straps and stable data.

// File: rtl/regbuf_fanout.sv
module regbuf_fanout #(
  parameter int IN_W   = 25,
  parameter int HALF_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fanout_mode,
  input  logic                upper_sel,
  input  logic [IN_W-1:0]     din,
  output logic [2*HALF_W-1:0] dout
);
  localparam int OUT_W = 2 * HALF_W;
  localparam int B_LSB = IN_W - HALF_W;

  logic [HALF_W-1:0] half_src;
  logic [OUT_W-1:0]  nxt;

  assign half_src = upper_sel ? din[IN_W-1:B_LSB] : din[HALF_W-1:0];
  assign nxt      = fanout_mode ? {half_src, half_src} : OUT_W'(din);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dout <= '0;
    else        dout <= nxt;

  assert_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fanout_mode |=> dout[IN_W-1:0] == $past(din));

  assert_spare_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fanout_mode |=> dout[OUT_W-1:IN_W] == '0);

  assert_bank_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fanout_mode && !upper_sel) |=>
      (dout[HALF_W-1:0] == $past(din[HALF_W-1:0])) &&
      (dout[OUT_W-1:HALF_W] == $past(din[HALF_W-1:0])));

  assert_bank_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fanout_mode && upper_sel) |=>
      (dout[HALF_W-1:0] == $past(din[IN_W-1:B_LSB])) &&
      (dout[OUT_W-1:HALF_W] == $past(din[IN_W-1:B_LSB])));

  assert_reset_clear_R6: assert property (@(posedge clk) disable iff (rst_n)
    dout == '0);

  assert_straps_static_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(fanout_mode) && $stable(upper_sel));
endmodule

// File: tb/regbuf_fanout_tb.sv
module regbuf_fanout_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fanout_mode = 1'b0;
  logic        upper_sel = 1'b0;
  logic [24:0] din = '0;
  logic [27:0] dout;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbuf_fanout u_dut (
    .clk(clk), .rst_n(rst_n), .fanout_mode(fanout_mode),
    .upper_sel(upper_sel), .din(din), .dout(dout)
  );

  function automatic logic [27:0] model(logic [24:0] d, logic m, logic s);
    logic [27:0] r = '0;
    int base;
    if (!m) begin
      for (int i = 0; i < 25; i++) r[i] = d[i];
    end else begin
      base = s ? 11 : 0;
      for (int i = 0; i < 14; i++) begin
        r[i]      = d[base + i];
        r[i + 14] = d[base + i];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Straps change only under reset (R8); release falls on a falling edge.
  task automatic run_cfg(input logic m, input logic s, input int n, input string tag);
    logic [27:0] exp;
    logic [24:0] d;
    @(negedge clk);
    rst_n = 1'b0;
    fanout_mode = m;
    upper_sel = s;
    din = 25'($urandom);
    #1 check("R6 reset hold", dout, '0);
    repeat (2) @(negedge clk);
    check("R6 reset over edges", dout, '0);
    d = 25'($urandom);
    din = d;
    rst_n = 1'b1;
    exp = model(d, m, s);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(k == 0 ? {"R7 first capture ", tag} : tag, dout, exp);
      d = 25'($urandom);
      if (k == 3) d = '1;
      if (k == 4) d = '0;
      din = d;
      exp = model(d, m, s);
    end
  endtask

  initial begin
    logic [27:0] ref0;
    repeat (3) @(negedge clk);
    check("R6 initial", dout, '0);

    run_cfg(1'b0, 1'b0, 200, "R1 R2 direct");
    run_cfg(1'b0, 1'b1, 200, "R5 sel ignored");
    run_cfg(1'b1, 1'b0, 200, "R3 bank A");
    run_cfg(1'b1, 1'b1, 200, "R4 bank B");

    // R6: asynchronous clear in the middle of a cycle
    @(negedge clk);
    din = 25'h1FFFFFF;
    @(negedge clk);
    check("R4 before async reset", dout, 28'hFFFFFFF);
    #1 rst_n = 1'b0;
    #1 check("R6 async clear", dout, '0);

    // R5: the same data gives the same result for both selects in direct mode
    @(negedge clk);
    fanout_mode = 1'b0;
    upper_sel = 1'b1;
    @(negedge clk);
    din = 25'h0ABCDEF;
    rst_n = 1'b1;
    @(negedge clk);
    ref0 = model(25'h0ABCDEF, 1'b0, 1'b0);
    check("R5 direct sel=1", dout, ref0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule